// File: doc/BRIEF.md
# Capture-Compare Event Timer

A 32-bit up-counting timer for general system timing, driven through a single-cycle register port. Software sets a run bit to start and stop it. The counter can tick every clock or through a power-of-two prescaler. On overflow it either reloads from a load register or wraps to zero and halts. A compare register raises a match event when the counter steps onto its value. Software can also load the counter directly, or from the load register by writing a trigger address.

An external capture input is synchronized and edge-detected. On a selected edge the current count is latched into a capture register. A dual mode fills two capture registers from consecutive edges. An event output pin can pulse or toggle on overflow and on compare, from a programmable idle level. Three interrupt sources (match, overflow, capture) set sticky status bits. Software clears these bits by writing ones to them. Separate set and clear addresses build an enable mask, and the interrupt line is the OR of all enabled pending bits.

Register addresses (word index on `reg_addr`): 0 control, 1 counter, 2 load, 3 trigger, 4 compare, 5 capture A, 6 capture B, 7 raw status, 8 masked status (write-one-to-clear), 9 enable set (reads back the mask), 10 enable clear.

Top module: `cct_timer`

## Requirements
- R1: While control bit 0 (run) is 1 the counter adds one on every tick; with the prescaler off a tick is every clock. Writing the bit as 0 freezes the count.
- R2: Control bit 5 enables the prescaler, and control bits 4:2 hold a ratio r. With the prescaler on, one tick occurs every 2^(r+1) clocks of running.
- R3: A tick taken at count 0xFFFFFFFF is an overflow and sets status bit 1. If control bit 1 (auto-reload) is 1, the counter takes the load value. Otherwise the counter becomes 0 and the run bit clears itself.
- R4: With control bit 6 (compare enable) set, status bit 0 sets on the tick that moves the counter onto the compare value. With bit 6 clear, no match status is raised.
- R5: A write to address 1 sets the counter to the written data. A write to address 3 (any data) copies the load register into the counter. Either write wins over a tick in the same cycle.
- R6: Control bits 9:8 select the capture edge of `cap_in`: 0 none, 1 rising, 2 falling, 3 both. The input passes through two synchronizing flops. On a selected edge the count goes to capture A (address 5) and sets status bit 2.
- R7: With control bit 13 set, the first selected edge fills capture A without raising status, and the second fills capture B (address 6) and sets status bit 2. Any control write restarts the pair.
- R8: Address 7 reads the raw status and address 8 reads status ANDed with the enable mask. Writing address 8 clears each status bit written as 1, and bits written as 0 keep their state.
- R9: Writing ones to address 9 sets enable bits, and writing ones to address 10 clears them. `irq` is high exactly when some status bit and its enable bit are both 1.
- R10: Control bits 11:10 pick the events that drive `evt_out`: 0 none, 1 overflow, 2 overflow or match. Bit 7 is the idle level. With bit 12 at 1 the pin inverts on each event, and any control write resets this toggle state. With bit 12 at 0 the pin leaves its idle level from an event until the next tick, or until the timer stops.
- R11: After reset, control, counter, status and enable read 0, and `irq` and `evt_out` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| cap_in | input | 1 | Asynchronous capture input |
| evt_out | output | 1 | Pulse/toggle event output |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check several properties on every cycle. They check the single-step increment and the overflow reload, and that the run bit self-clears on a wrap without reload. They also check that ticks stay spaced while the prescaler is on, that the capture A value equals the count at the edge, that a pulse ends at a tick, and the write-one-to-clear of overflow status. Only the bench scenarios can show the end-to-end behaviour. These include the exact tick counts over a run for each prescale ratio, compare timing against the event pin, and edge-mode filtering of the capture input. They also include the pairing order in dual-capture mode and how the enable mask gates the interrupt line.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int CTRL_W = 16;
  localparam int PR_W   = 3;
  localparam int IRQ_N  = 3;

  // interrupt source positions in status and enable
  localparam int IRQ_MATCH = 0;
  localparam int IRQ_OVF   = 1;
  localparam int IRQ_CAP   = 2;

  typedef struct packed {
    logic [1:0]      spare;     // 15:14
    logic            dual_cap;  // 13
    logic            toggle;    // 12
    logic [1:0]      evt_sel;   // 11:10
    logic [1:0]      cap_edge;  // 9:8
    logic            idle_lvl;  // 7
    logic            cmp_en;    // 6
    logic            pre_en;    // 5
    logic [PR_W-1:0] ratio;     // 4:2
    logic            auto_rld;  // 1
    logic            run;       // 0
  } ctrl_t;

  typedef enum logic [3:0] {
    A_CTRL  = 4'd0,
    A_COUNT = 4'd1,
    A_LOAD  = 4'd2,
    A_TRIG  = 4'd3,
    A_CMP   = 4'd4,
    A_CAPA  = 4'd5,
    A_CAPB  = 4'd6,
    A_RAW   = 4'd7,
    A_STAT  = 4'd8,
    A_IESET = 4'd9,
    A_IECLR = 4'd10
  } reg_addr_e;
endpackage

// File: rtl/cct_prescaler.sv
module cct_prescaler #(
  parameter int PR_W = 3,
  localparam int DIV_W = 1 << PR_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_i,
  input  logic            pre_en_i,
  input  logic [PR_W-1:0] ratio_i,
  output logic            tick_o
);
  logic [DIV_W-1:0] div_q, div_d, lim;
  logic [PR_W:0]    shamt;

  always_comb begin
    shamt = {1'b0, ratio_i} + {{PR_W{1'b0}}, 1'b1};
    lim   = (DIV_W'(1) << shamt) - DIV_W'(1);
    tick_o = run_i & (~pre_en_i | (div_q == lim));
    if (!run_i || !pre_en_i)   div_d = '0;
    else if (div_q == lim)     div_d = '0;
    else                       div_d = div_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // R2: with the divider active two ticks never fall on adjacent clocks
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && pre_en_i) |=> (!tick_o || !pre_en_i));
endmodule

// File: rtl/cct_capture.sv
module cct_capture #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_i,
  input  logic [1:0]       edge_i,
  input  logic             dual_i,
  input  logic             ctrl_wr_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] capa_o,
  output logic [CNT_W-1:0] capb_o,
  output logic             done_o
);
  logic s1_q, s2_q, s3_q;
  logic ptr_q, ptr_d;
  logic [CNT_W-1:0] capa_d, capb_d;
  logic rise, fall, hit;

  always_comb begin
    rise = s2_q & ~s3_q;
    fall = ~s2_q & s3_q;
    case (edge_i)
      2'd1:    hit = rise;
      2'd2:    hit = fall;
      2'd3:    hit = rise | fall;
      default: hit = 1'b0;
    endcase
    capa_d = capa_o;
    capb_d = capb_o;
    ptr_d  = ptr_q;
    done_o = 1'b0;
    if (hit) begin
      if (dual_i && ptr_q) begin
        capb_d = cnt_i;
        ptr_d  = 1'b0;
        done_o = 1'b1;
      end else begin
        capa_d = cnt_i;
        ptr_d  = dual_i;
        done_o = ~dual_i;
      end
    end
    if (ctrl_wr_i) ptr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      s3_q   <= 1'b0;
      ptr_q  <= 1'b0;
      capa_o <= '0;
      capb_o <= '0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      s3_q   <= s2_q;
      ptr_q  <= ptr_d;
      capa_o <= capa_d;
      capb_o <= capb_d;
    end
  end

  // R6: capture A holds the count seen at the qualifying edge
  p_capa_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !(dual_i && ptr_q)) |=> (capa_o == $past(cnt_i)));
endmodule

// File: rtl/cct_outgen.sv
module cct_outgen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       run_i,
  input  logic       ovf_i,
  input  logic       match_i,
  input  logic [1:0] sel_i,
  input  logic       toggle_i,
  input  logic       idle_i,
  input  logic       ctrl_wr_i,
  output logic       pin_o
);
  logic tog_q, tog_d, pul_q, pul_d, evt;

  always_comb begin
    case (sel_i)
      2'd1:    evt = ovf_i;
      2'd2:    evt = ovf_i | match_i;
      default: evt = 1'b0;
    endcase
    tog_d = tog_q;
    pul_d = pul_q;
    if (ctrl_wr_i) begin
      tog_d = 1'b0;
      pul_d = 1'b0;
    end else if (evt) begin
      if (toggle_i) tog_d = ~tog_q;
      else          pul_d = 1'b1;
    end else if (tick_i || !run_i) begin
      pul_d = 1'b0;
    end
    pin_o = idle_i ^ (toggle_i ? tog_q : pul_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
      pul_q <= 1'b0;
    end else begin
      tog_q <= tog_d;
      pul_q <= pul_d;
    end
  end

  // R10: a pulse ends at the next tick that brings no new event
  p_pulse_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pul_q && tick_i && !evt && !ctrl_wr_i) |=> !pul_q);
endmodule

// File: rtl/cct_timer.sv
module cct_timer
  import cct_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  input  logic              cap_in,
  output logic              evt_out,
  output logic              irq
);
  logic rs1_q, rst_sn;
  ctrl_t ctrl_q, ctrl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_tick, load_q, load_d, cmp_q, cmp_d;
  logic [CNT_W-1:0] capa, capb;
  logic [IRQ_N-1:0] raw_q, raw_d, ien_q, ien_d, evts;
  logic wr_ctrl, wr_cnt, wr_load, wr_trig, wr_cmp, wr_stat, wr_ieset, wr_ieclr;
  logic tick, at_max, ovf_evt, match_evt, cap_evt, run_clr;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q  <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rs1_q  <= 1'b1;
      rst_sn <= rs1_q;
    end
  end

  always_comb begin
    wr_ctrl  = reg_wr & (reg_addr == ADDR_W'(A_CTRL));
    wr_cnt   = reg_wr & (reg_addr == ADDR_W'(A_COUNT));
    wr_load  = reg_wr & (reg_addr == ADDR_W'(A_LOAD));
    wr_trig  = reg_wr & (reg_addr == ADDR_W'(A_TRIG));
    wr_cmp   = reg_wr & (reg_addr == ADDR_W'(A_CMP));
    wr_stat  = reg_wr & (reg_addr == ADDR_W'(A_STAT));
    wr_ieset = reg_wr & (reg_addr == ADDR_W'(A_IESET));
    wr_ieclr = reg_wr & (reg_addr == ADDR_W'(A_IECLR));
  end

  cct_prescaler #(.PR_W(PR_W)) i_pre (
    .clk      (clk),
    .rst_n    (rst_sn),
    .run_i    (ctrl_q.run),
    .pre_en_i (ctrl_q.pre_en),
    .ratio_i  (ctrl_q.ratio),
    .tick_o   (tick)
  );

  // counter next state: tick first, then software writes take priority
  always_comb begin
    at_max   = (cnt_q == {CNT_W{1'b1}});
    ovf_evt  = tick & at_max;
    run_clr  = 1'b0;
    cnt_tick = cnt_q;
    if (tick) begin
      if (!at_max)                cnt_tick = cnt_q + CNT_W'(1);
      else if (ctrl_q.auto_rld)   cnt_tick = load_q;
      else begin
        cnt_tick = '0;
        run_clr  = 1'b1;
      end
    end
    match_evt = tick & ctrl_q.cmp_en & (cnt_tick == cmp_q);
    cnt_d = cnt_tick;
    if (wr_trig) cnt_d = load_q;
    if (wr_cnt)  cnt_d = reg_wdata;

    ctrl_d = ctrl_q;
    if (run_clr) ctrl_d.run = 1'b0;
    if (wr_ctrl) ctrl_d = ctrl_t'(reg_wdata[CTRL_W-1:0]);
    load_d = wr_load ? reg_wdata : load_q;
    cmp_d  = wr_cmp  ? reg_wdata : cmp_q;
  end

  cct_capture #(.CNT_W(CNT_W)) i_cap (
    .clk       (clk),
    .rst_n     (rst_sn),
    .pin_i     (cap_in),
    .edge_i    (ctrl_q.cap_edge),
    .dual_i    (ctrl_q.dual_cap),
    .ctrl_wr_i (wr_ctrl),
    .cnt_i     (cnt_q),
    .capa_o    (capa),
    .capb_o    (capb),
    .done_o    (cap_evt)
  );

  cct_outgen i_out (
    .clk       (clk),
    .rst_n     (rst_sn),
    .tick_i    (tick),
    .run_i     (ctrl_q.run),
    .ovf_i     (ovf_evt),
    .match_i   (match_evt),
    .sel_i     (ctrl_q.evt_sel),
    .toggle_i  (ctrl_q.toggle),
    .idle_i    (ctrl_q.idle_lvl),
    .ctrl_wr_i (wr_ctrl),
    .pin_o     (evt_out)
  );

  // status and enable: new events win over a same-cycle clear
  always_comb begin
    evts            = '0;
    evts[IRQ_MATCH] = match_evt;
    evts[IRQ_OVF]   = ovf_evt;
    evts[IRQ_CAP]   = cap_evt;
    raw_d = raw_q;
    if (wr_stat) raw_d = raw_q & ~reg_wdata[IRQ_N-1:0];
    raw_d = raw_d | evts;
    ien_d = ien_q;
    if (wr_ieset) ien_d = ien_d | reg_wdata[IRQ_N-1:0];
    if (wr_ieclr) ien_d = ien_d & ~reg_wdata[IRQ_N-1:0];
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
      load_q <= '0;
      cmp_q  <= '0;
      raw_q  <= '0;
      ien_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      cnt_q  <= cnt_d;
      load_q <= load_d;
      cmp_q  <= cmp_d;
      raw_q  <= raw_d;
      ien_q  <= ien_d;
    end
  end

  assign irq = |(raw_q & ien_q);

  always_comb begin
    case (reg_addr)
      ADDR_W'(A_CTRL):  reg_rdata = CNT_W'(ctrl_q);
      ADDR_W'(A_COUNT): reg_rdata = cnt_q;
      ADDR_W'(A_LOAD):  reg_rdata = load_q;
      ADDR_W'(A_CMP):   reg_rdata = cmp_q;
      ADDR_W'(A_CAPA):  reg_rdata = capa;
      ADDR_W'(A_CAPB):  reg_rdata = capb;
      ADDR_W'(A_RAW):   reg_rdata = CNT_W'(raw_q);
      ADDR_W'(A_STAT):  reg_rdata = CNT_W'(raw_q & ien_q);
      ADDR_W'(A_IESET): reg_rdata = CNT_W'(ien_q);
      default:          reg_rdata = '0;
    endcase
  end

  // R1: a plain tick advances the count by exactly one
  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_sn)
    (tick && !at_max && !wr_cnt && !wr_trig) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  // R3: overflow with auto-reload lands on the load value
  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (tick && at_max && ctrl_q.auto_rld && !wr_cnt && !wr_trig && !wr_load)
      |=> (cnt_q == $past(load_q)));

  // R3: overflow without auto-reload halts the timer
  p_halt_wrap_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (tick && at_max && !ctrl_q.auto_rld && !wr_ctrl) |=> !ctrl_q.run);

  // R8: a one written to the overflow status bit clears it
  p_ovf_clear_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_stat && reg_wdata[IRQ_OVF] && !ovf_evt) |=> !raw_q[IRQ_OVF]);
endmodule

// File: tb/test_cct_timer.sv
module test_cct_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = 4'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        cap_in = 1'b0;
  logic        evt_out, irq;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cct_timer i_cct_timer (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_in(cap_in),
    .evt_out(evt_out), .irq(irq)
  );

  typedef struct packed {
    logic        pre;
    logic [2:0]  ratio;
    logic [31:0] init;
    logic [7:0]  idle;
    logic [31:0] expv;
  } vec_t;

  // counting runs: ticks = floor((idle+1) / divide)
  localparam vec_t VECS [5] = '{
    '{1'b0, 3'd0, 32'd10,         8'd4,  32'd15},
    '{1'b1, 3'd0, 32'd0,          8'd9,  32'd5},
    '{1'b1, 3'd1, 32'd100,        8'd10, 32'd102},
    '{1'b1, 3'd2, 32'd7,          8'd15, 32'd9},
    '{1'b0, 3'd0, 32'hFFFF_0000,  8'd0,  32'hFFFF_0001}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_cap(input logic v);
    cap_in = v;
    idle(5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle(2);
    rst_n = 1'b1;
    idle(4);

    // R11 reset state
    rd(4'd0, v); chk("R11 ctrl", v, 32'd0);
    rd(4'd1, v); chk("R11 count", v, 32'd0);
    rd(4'd7, v); chk("R11 status", v, 32'd0);
    rd(4'd9, v); chk("R11 enable", v, 32'd0);
    chk("R11 irq", {31'd0, irq}, 32'd0);
    chk("R11 evt_out", {31'd0, evt_out}, 32'd0);

    // R1 / R2 counting table
    foreach (VECS[i]) begin
      wr(4'd1, VECS[i].init);
      wr(4'd0, 32'd1 | (32'(VECS[i].pre) << 5) | (32'(VECS[i].ratio) << 2));
      idle(int'(VECS[i].idle));
      wr(4'd0, 32'd0);
      rd(4'd1, v);
      chk(VECS[i].pre ? "R2 prescaled count" : "R1 count", v, VECS[i].expv);
    end
    idle(3);
    rd(4'd1, v); chk("R1 frozen when stopped", v, 32'hFFFF_0001);

    // R3 overflow without reload
    wr(4'd1, 32'hFFFF_FFFE);
    wr(4'd0, 32'd1);
    idle(4);
    rd(4'd1, v); chk("R3 wrap to zero", v, 32'd0);
    rd(4'd0, v); chk("R3 run cleared", v, 32'd0);
    rd(4'd7, v); chk("R3 ovf status", v, 32'd2);

    // R9 / R8 enable mask and clearing
    chk("R9 irq masked", {31'd0, irq}, 32'd0);
    wr(4'd9, 32'd2);
    chk("R9 irq enabled", {31'd0, irq}, 32'd1);
    rd(4'd8, v); chk("R8 masked status", v, 32'd2);
    wr(4'd10, 32'd2);
    chk("R9 irq cleared enable", {31'd0, irq}, 32'd0);
    rd(4'd8, v); chk("R8 masked after disable", v, 32'd0);
    wr(4'd8, 32'd1);
    rd(4'd7, v); chk("R8 zero bits keep state", v, 32'd2);
    wr(4'd8, 32'd2);
    rd(4'd7, v); chk("R8 w1c", v, 32'd0);

    // R3 auto-reload
    wr(4'd2, 32'd5);
    wr(4'd1, 32'hFFFF_FFFF);
    wr(4'd0, 32'd3);
    wr(4'd0, 32'd0);
    rd(4'd1, v); chk("R3 reload", v, 32'd5);
    wr(4'd8, 32'h7);

    // R5 trigger and direct write
    wr(4'd2, 32'h1234);
    wr(4'd1, 32'd7);
    rd(4'd1, v); chk("R5 direct write", v, 32'd7);
    wr(4'd3, 32'hDEAD);
    rd(4'd1, v); chk("R5 trigger reload", v, 32'h1234);

    // R4 compare
    wr(4'd4, 32'd20);
    wr(4'd1, 32'd15);
    wr(4'd0, 32'h41);
    idle(6);
    wr(4'd0, 32'd0);
    rd(4'd7, v); chk("R4 match status", v, 32'd1);
    wr(4'd8, 32'h7);
    wr(4'd4, 32'd2);
    wr(4'd1, 32'd0);
    wr(4'd0, 32'h01);
    idle(3);
    wr(4'd0, 32'd0);
    rd(4'd7, v); chk("R4 compare disabled", v, 32'd0);

    // R10 toggle on overflow or match
    wr(4'd4, 32'd3);
    wr(4'd1, 32'd0);
    wr(4'd0, 32'h1841);
    idle(2);
    chk("R10 toggle before match", {31'd0, evt_out}, 32'd0);
    idle(1);
    chk("R10 toggle at match", {31'd0, evt_out}, 32'd1);
    wr(4'd0, 32'h80);
    chk("R10 idle level high", {31'd0, evt_out}, 32'd1);
    wr(4'd0, 32'd0);
    chk("R10 idle level low", {31'd0, evt_out}, 32'd0);
    // overflow-only selection ignores match
    wr(4'd4, 32'd2);
    wr(4'd1, 32'd0);
    wr(4'd0, 32'h1441);
    idle(3);
    chk("R10 match not selected", {31'd0, evt_out}, 32'd0);
    wr(4'd0, 32'd0);

    // R10 pulse on overflow
    wr(4'd2, 32'd0);
    wr(4'd1, 32'hFFFF_FFFE);
    wr(4'd0, 32'h403);
    idle(1);
    chk("R10 pulse before ovf", {31'd0, evt_out}, 32'd0);
    idle(1);
    chk("R10 pulse at ovf", {31'd0, evt_out}, 32'd1);
    idle(1);
    chk("R10 pulse one tick", {31'd0, evt_out}, 32'd0);
    wr(4'd0, 32'd0);
    wr(4'd8, 32'h7);

    // R6 capture edge modes
    wr(4'd0, 32'h100);
    wr(4'd1, 32'hAA);
    pulse_cap(1'b1);
    rd(4'd5, v); chk("R6 rising capture", v, 32'hAA);
    rd(4'd7, v); chk("R6 capture status", v, 32'd4);
    wr(4'd8, 32'd4);
    wr(4'd1, 32'hBB);
    pulse_cap(1'b0);
    rd(4'd5, v); chk("R6 falling ignored", v, 32'hAA);
    rd(4'd7, v); chk("R6 no status on ignored edge", v, 32'd0);
    wr(4'd0, 32'h300);
    wr(4'd1, 32'hCC);
    pulse_cap(1'b1);
    rd(4'd5, v); chk("R6 both edges", v, 32'hCC);
    wr(4'd8, 32'd4);
    wr(4'd0, 32'h000);
    wr(4'd1, 32'hDD);
    pulse_cap(1'b0);
    rd(4'd5, v); chk("R6 edge none", v, 32'hCC);

    // R7 dual capture
    wr(4'd0, 32'h2100);
    wr(4'd1, 32'h11);
    pulse_cap(1'b1);
    pulse_cap(1'b0);
    rd(4'd5, v); chk("R7 first to A", v, 32'h11);
    rd(4'd7, v); chk("R7 no status after first", v, 32'd0);
    wr(4'd1, 32'h22);
    pulse_cap(1'b1);
    rd(4'd6, v); chk("R7 second to B", v, 32'h22);
    rd(4'd7, v); chk("R7 status after second", v, 32'd4);
    wr(4'd9, 32'd4);
    chk("R9 irq from capture", {31'd0, irq}, 32'd1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule